// File: doc/BRIEF.md
# Per-Channel State Accumulator with Read-Modify-Write Pipeline

This block keeps one state word for each channel of a time-division-multiplexed datapath. In every clock slot, one channel index arrives together with an operand. The engine fetches that channel's stored word from a memory array through a read-only port. In the following stage it adds the operand, and one clock after that it stores the sum through a second port that only writes. The updated word leaves the block together with its channel number and a valid flag.

Because the write lands two clock edges after the index is sampled, a later slot can read a word that is out of date. Two forwarding taps fix this. One takes the result that has just been computed, from the update stage. The other takes the word that is being written in the same cycle. With these taps, any sequence of slots gives the same result as applying the updates one at a time. The state width and the channel count are parameters. Every stored word is zero at start-up.

Top module: `chan_state_rmw`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `upd_valid` is 0.
- R2: A slot sampled with `slot_valid`=1 at clock edge k produces `upd_valid`=1 after edge k+1. In that cycle `upd_chan` equals the sampled channel and `upd_state` equals that channel's previous state plus `slot_operand`.
- R3: A slot sampled with `slot_valid`=0 produces `upd_valid`=0 after the next edge. It leaves every stored state unchanged, whatever its channel and operand are.
- R4: Valid slots for the same channel in consecutive cycles each see the result of the slot before them.
- R5: Valid slots for the same channel two cycles apart, with another channel or an idle slot between them, see the earlier result.
- R6: Every channel's state is zero before its first update.
- R7: The addition wraps modulo 2^STATE_W.
- R8: Reset clears only the pipeline. Stored states written before reset are kept.
- R9: Channels are independent, and this includes channel 0 and channel NUM_CH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline |
| slot_valid | input | 1 | The slot carries an update |
| slot_chan | input | $clog2(NUM_CH) | Channel index of the slot |
| slot_operand | input | STATE_W | Value added to the channel state |
| upd_valid | output | 1 | The result is valid |
| upd_chan | output | $clog2(NUM_CH) | Channel of the result |
| upd_state | output | STATE_W | Updated state of that channel |

## Verification
A slot driven before clock edge k shows its result after edge k+1. The bench therefore drives inputs on falling edges and checks each result two falling edges after it was driven, using a two-entry queue of expected results. The expected values come from a reference array in the bench that applies the updates one at a time in slot order. Because of this, the same-channel sequences at distances of one and two slots compare the forwarded results against a fully serial model. After an idle flush, channel 0 is read back with a zero operand. This shows through the result port that the invalid slot left the stored state unchanged. Reading channels back after a reset shows that the stored state survived it.

// File: rtl/chan_state_rmw.sv
module chan_state_rmw #(
  parameter int STATE_W = 16,
  parameter int NUM_CH  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      slot_valid,
  input  logic [$clog2(NUM_CH)-1:0] slot_chan,
  input  logic [STATE_W-1:0]        slot_operand,
  output logic                      upd_valid,
  output logic [$clog2(NUM_CH)-1:0] upd_chan,
  output logic [STATE_W-1:0]        upd_state
);
  localparam int CW = $clog2(NUM_CH);

  logic [STATE_W-1:0] store [NUM_CH];
  logic [STATE_W-1:0] rd_word;
  logic               a_vld;
  logic [CW-1:0]      a_chan;
  logic [STATE_W-1:0] a_opnd;
  logic               b_vld;
  logic [CW-1:0]      b_chan;
  logic [STATE_W-1:0] b_word;
  logic               w_vld;
  logic [CW-1:0]      w_chan;
  logic [STATE_W-1:0] w_word;
  logic [STATE_W-1:0] base_word;

  initial for (int i = 0; i < NUM_CH; i++) store[i] = '0;

  // read port
  always_ff @(posedge clk)
    if (slot_valid) rd_word <= store[slot_chan];

  // write port, one clock behind the update stage
  always_ff @(posedge clk)
    if (b_vld) store[b_chan] <= b_word;

  // newest copy wins: update stage, then the word being written
  assign base_word = (b_vld && b_chan == a_chan) ? b_word :
                     (w_vld && w_chan == a_chan) ? w_word : rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vld <= 1'b0;
      b_vld <= 1'b0;
      w_vld <= 1'b0;
    end else begin
      a_vld <= slot_valid;
      b_vld <= a_vld;
      w_vld <= b_vld;
    end
    a_chan <= slot_chan;
    a_opnd <= slot_operand;
    b_chan <= a_chan;
    b_word <= base_word + a_opnd;
    w_chan <= b_chan;
    w_word <= b_word;
  end

  assign upd_valid = b_vld;
  assign upd_chan  = b_chan;
  assign upd_state = b_word;

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> !upd_valid);

  assert_result_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot_valid, 2) && $past(rst_n) && $past(rst_n, 2))
      |-> (upd_valid && upd_chan == $past(slot_chan, 2)));

  assert_idle_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(slot_valid, 2)) |-> !upd_valid);

  assert_chained_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(upd_valid) && upd_chan == $past(upd_chan) && $past(rst_n, 2))
      |-> upd_state == $past(upd_state) + $past(slot_operand, 2));
endmodule

// File: tb/chan_state_rmw_test.sv
`timescale 1ns/1ps
module chan_state_rmw_test;
  localparam int SW = 16;
  localparam int NC = 64;
  localparam int CW = $clog2(NC);
  localparam int NV = 18;

  // {valid, chan, operand}
  localparam logic [1+CW+SW-1:0] VEC [NV] = '{
    {1'b1, 6'd3,  16'd5},
    {1'b1, 6'd3,  16'd7},
    {1'b1, 6'd3,  16'd1},
    {1'b0, 6'd3,  16'd0},
    {1'b1, 6'd10, 16'd100},
    {1'b1, 6'd11, 16'd1},
    {1'b1, 6'd10, 16'd50},
    {1'b1, 6'd63, 16'hFFFF},
    {1'b1, 6'd63, 16'd2},
    {1'b1, 6'd0,  16'h1234},
    {1'b0, 6'd0,  16'd9},
    {1'b0, 6'd5,  16'd3},
    {1'b1, 6'd3,  16'd0},
    {1'b1, 6'd20, 16'd0},
    {1'b1, 6'd11, 16'hFFFF},
    {1'b0, 6'd11, 16'd4},
    {1'b1, 6'd11, 16'd1},
    {1'b1, 6'd10, 16'd0}
  };

  logic clk = 0, rst_n = 0;
  logic slot_valid = 0;
  logic [CW-1:0] slot_chan = '0;
  logic [SW-1:0] slot_operand = '0;
  logic upd_valid;
  logic [CW-1:0] upd_chan;
  logic [SW-1:0] upd_state;

  int checks = 0, errors = 0;
  logic [SW-1:0] model [NC];
  logic [1+CW+SW-1:0] q0, q1;
  string t0, t1;
  logic [CW-1:0] prev1, prev2;
  logic pv1, pv2;

  always #4 clk = ~clk;

  chan_state_rmw #(.STATE_W(SW), .NUM_CH(NC)) uut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_chan(slot_chan),
    .slot_operand(slot_operand), .upd_valid(upd_valid), .upd_chan(upd_chan),
    .upd_state(upd_state));

  task automatic check_slot(input logic [1+CW+SW-1:0] e, input string tag);
    checks++;
    if (upd_valid !== e[CW+SW] ||
        (e[CW+SW] && (upd_chan !== e[SW+:CW] || upd_state !== e[SW-1:0]))) begin
      errors++;
      $display("FAIL %s: got v=%0b ch=%0d st=%h, expected v=%0b ch=%0d st=%h",
               tag, upd_valid, upd_chan, upd_state, e[CW+SW], e[SW+:CW], e[SW-1:0]);
    end
  endtask

  task automatic step(input logic v, input logic [CW-1:0] ch, input logic [SW-1:0] op);
    string tg;
    @(negedge clk);
    check_slot(q1, t1);
    q1 = q0; t1 = t0;
    slot_valid = v; slot_chan = ch; slot_operand = op;
    if (!v) tg = "R3";
    else if (pv1 && prev1 == ch) tg = "R4";
    else if (pv2 && prev2 == ch) tg = "R5";
    else if ({1'b0, model[ch]} + {1'b0, op} > {1'b0, {SW{1'b1}}}) tg = "R7";
    else tg = "R2";
    if (v) model[ch] = model[ch] + op;
    q0 = {v, ch, model[ch]}; t0 = tg;
    pv2 = pv1; prev2 = prev1; pv1 = v; prev1 = ch;
  endtask

  task automatic do_reset();
    @(negedge clk);
    slot_valid = 0; rst_n = 0;
    q0 = '0; q1 = '0; t0 = "R1"; t1 = "R1"; pv1 = 0; pv2 = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (upd_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got upd_valid=%0b during reset, expected 0", upd_valid);
    end
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) model[i] = '0;
    do_reset();
    for (int i = 0; i < NV; i++) step(VEC[i][CW+SW], VEC[i][SW+:CW], VEC[i][SW-1:0]);
    step(0, 0, 0); step(0, 0, 0);
    // R3: the invalid slot on channel 0 must not have changed it
    step(1, 0, 0); t0 = "R3";
    // R6: never-touched channels read zero; R9: extremes are independent
    step(1, 6'd42, 16'd0); t0 = "R6";
    step(1, 6'd62, 16'd0); t0 = "R9";
    step(1, 6'd63, 16'd0); t0 = "R9";
    step(1, 6'd0, 16'd1);  t0 = "R9";
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    // R8: reset keeps stored words
    do_reset();
    step(0, 0, 0);
    step(1, 6'd3, 16'd0);  t0 = "R8";
    step(1, 6'd63, 16'd0); t0 = "R8";
    step(1, 6'd10, 16'd4); t0 = "R8";
    step(1, 6'd10, 16'd4);
    step(1, 6'd63, 16'd1);
    step(1, 6'd10, 16'd4);
    step(0, 0, 0); step(0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule